// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Primary Cache

This block is a small, fully associative store for whole cache lines that a direct-mapped primary cache has just pushed out. It sits beside the primary cache and is searched only when that cache misses. The search compares the complete line address of the miss against every held entry. Because there is no set index, the full line address serves as the tag.

On a hit, the block returns the stored line and its dirty flag one cycle after the request. In the same operation, the line that the primary cache is evicting takes over the entry that was hit, so the two lines swap places. On a miss, the evicted line is written into the slot that the insertion ring points at, and the request goes on to the next memory level.

If the ring slot still holds a valid dirty line when it is overwritten, that line leaves through a write-back output. Frequently used lines that fight over one primary index therefore bounce between the two structures and do not go back to main memory.

Top module: `victim_buffer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid` and `wb_valid` are low. After reset every entry is empty, so any lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R3: A lookup hits when `req_addr` equals the stored address of a valid entry. `rsp_hit` is then 1, `rsp_data` is that entry's line and `rsp_dirty` is that entry's dirty flag. At most one entry matches.
- R4: On a hit with `evict_valid` high, the evicted line (address, data, dirty flag) replaces the hit entry. A later lookup of the evicted address hits with its data, and a lookup of the address that was hit misses.
- R5: On a hit with `evict_valid` low, the hit entry becomes empty, and a repeat lookup of that address misses.
- R6: On a miss with `evict_valid` high, the evicted line is written into the slot selected by an insertion ring. The ring starts at slot 0 after reset and advances by one, wrapping after the last slot, only on such an insertion. Sixteen consecutive insertions are all held at once.
- R7: When an insertion overwrites a slot that holds a valid dirty line, `wb_valid` pulses in the next cycle with that line's address on `wb_addr` and its data on `wb_data`. Overwriting an empty slot or a clean line gives no pulse.
- R8: With `req_valid` low, the evict inputs have no effect: no entry changes and the ring does not advance.
- R9: A miss with `evict_valid` low changes no entry and does not advance the ring.
- R10: With a direct-mapped primary cache using the buffer, an access stream that alternates between two addresses of the same primary index hits, after its first two accesses, in either the primary cache or the buffer on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Primary-cache miss lookup request |
| req_addr | input | ADDR_W | Line address that missed in the primary cache |
| evict_valid | input | 1 | The primary cache is evicting a valid line with this request |
| evict_addr | input | ADDR_W | Line address of the evicted line |
| evict_data | input | DATA_W | Contents of the evicted line |
| evict_dirty | input | 1 | Evicted line is modified |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | The lookup found the line |
| rsp_data | output | DATA_W | Line contents on a hit, zero on a miss |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| wb_valid | output | 1 | A dirty line has been displaced and must be written back |
| wb_addr | output | ADDR_W | Line address of the displaced dirty line |
| wb_data | output | DATA_W | Contents of the displaced dirty line |

## Verification
On every cycle, the assertions check the one-cycle response timing, that at most one entry matches a lookup, that a write-back appears only with a missed lookup that carried an eviction, and that idle cycles leave the valid flags untouched. Only the bench scenarios can show that data and dirty flags survive a swap, that the ring replaces entries in insertion order and skips neither a swap nor an idle cycle, and that the alternating same-index stream stops going to memory after its first two accesses.

// File: rtl/vc_pkg.sv
package vc_pkg;

   typedef enum logic [1:0] {
      VC_NOP  = 2'd0,
      VC_SWAP = 2'd1,
      VC_DROP = 2'd2,
      VC_FILL = 2'd3
   } vc_act_e;

   function automatic bit vc_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/vc_ring_ptr.sv
module vc_ring_ptr #(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   import vc_pkg::*;

   logic [IDX_W-1:0] ptr_nxt;

   generate
      if (vc_is_pow2(ENTRIES)) begin : g_natural_wrap
         assign ptr_nxt = ptr + 1'b1;
      end else begin : g_explicit_wrap
         assign ptr_nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr_nxt;
   end

endmodule

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ADDR_W  = 26,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ADDR_W-1:0]  tag_arr [ENTRIES],
   input  logic [ADDR_W-1:0]  look_addr,
   output logic [ENTRIES-1:0] match_vec,
   output logic               any_hit,
   output logic [IDX_W-1:0]   hit_idx
);

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign match_vec[e] = valid_vec[e] && (tag_arr[e] == look_addr);
      end
   endgenerate

   assign any_hit = |match_vec;

   always_comb begin
      hit_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match_vec[e]) hit_idx = IDX_W'(e);
      end
   end

endmodule

// File: rtl/vc_line_store.sv
module vc_line_store #(
   parameter int unsigned ENTRIES    = 16,
   parameter int unsigned ADDR_W     = 26,
   parameter int unsigned DATA_W     = 64,
   parameter bit          CLEAR_DATA = 1'b0,
   localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               wr_dirty,
   input  logic               inv_en,
   input  logic [IDX_W-1:0]   inv_idx,
   output logic [ENTRIES-1:0] valid_vec,
   output logic [ENTRIES-1:0] dirty_vec,
   output logic [ADDR_W-1:0]  tag_arr  [ENTRIES],
   output logic [DATA_W-1:0]  data_arr [ENTRIES]
);

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         logic              v_r;
         logic              d_r;
         logic [ADDR_W-1:0] t_r;
         logic [DATA_W-1:0] l_r;
         logic              sel_wr;
         logic              sel_inv;

         assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(e));
         assign sel_inv = inv_en && (inv_idx == IDX_W'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_r <= 1'b0;
               d_r <= 1'b0;
               t_r <= '0;
            end else if (sel_wr) begin
               v_r <= 1'b1;
               d_r <= wr_dirty;
               t_r <= wr_addr;
            end else if (sel_inv) begin
               v_r <= 1'b0;
               d_r <= 1'b0;
            end
         end

         if (CLEAR_DATA) begin : g_data_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      l_r <= '0;
               else if (sel_wr) l_r <= wr_data;
            end
         end else begin : g_data_plain
            always_ff @(posedge clk) begin
               if (sel_wr) l_r <= wr_data;
            end
         end

         assign valid_vec[e] = v_r;
         assign dirty_vec[e] = d_r;
         assign tag_arr[e]   = t_r;
         assign data_arr[e]  = l_r;
      end
   endgenerate

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
   parameter int unsigned ENTRIES    = 16,
   parameter int unsigned ADDR_W     = 26,
   parameter int unsigned DATA_W     = 64,
   parameter bit          CLEAR_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic [DATA_W-1:0] evict_data,
   input  logic              evict_dirty,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_dirty,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0] wb_data
);
   import vc_pkg::*;

   localparam int unsigned IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("victim_buffer: ENTRIES must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("victim_buffer: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] dirty_vec;
   logic [ADDR_W-1:0]  tag_arr  [ENTRIES];
   logic [DATA_W-1:0]  data_arr [ENTRIES];
   logic [ENTRIES-1:0] match_vec;
   logic               any_hit;
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   ring_ptr;

   vc_act_e            act;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic               inv_en;
   logic               ring_adv;
   logic               displace_dirty;

   vc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) match_i (
      .valid_vec (valid_vec),
      .tag_arr   (tag_arr),
      .look_addr (req_addr),
      .match_vec (match_vec),
      .any_hit   (any_hit),
      .hit_idx   (hit_idx)
   );

   vc_ring_ptr #(.ENTRIES(ENTRIES)) ring_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (ring_adv),
      .ptr   (ring_ptr)
   );

   always_comb begin
      act = VC_NOP;
      if (req_valid) begin
         if (any_hit) act = evict_valid ? VC_SWAP : VC_DROP;
         else if (evict_valid) act = VC_FILL;
      end
   end

   assign wr_en          = (act == VC_SWAP) || (act == VC_FILL);
   assign wr_idx         = (act == VC_SWAP) ? hit_idx : ring_ptr;
   assign inv_en         = (act == VC_DROP);
   assign ring_adv       = (act == VC_FILL);
   assign displace_dirty = (act == VC_FILL) && valid_vec[ring_ptr] && dirty_vec[ring_ptr];

   vc_line_store #(
      .ENTRIES    (ENTRIES),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CLEAR_DATA (CLEAR_DATA)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_addr   (evict_addr),
      .wr_data   (evict_data),
      .wr_dirty  (evict_dirty),
      .inv_en    (inv_en),
      .inv_idx   (hit_idx),
      .valid_vec (valid_vec),
      .dirty_vec (dirty_vec),
      .tag_arr   (tag_arr),
      .data_arr  (data_arr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
         rsp_dirty <= 1'b0;
         wb_valid  <= 1'b0;
         wb_addr   <= '0;
         wb_data   <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_hit;
         rsp_data  <= (req_valid && any_hit) ? data_arr[hit_idx] : '0;
         rsp_dirty <= req_valid && any_hit && dirty_vec[hit_idx];
         wb_valid  <= displace_dirty;
         if (displace_dirty) begin
            wb_addr <= tag_arr[ring_ptr];
            wb_data <= data_arr[ring_ptr];
         end
      end
   end

endmodule

// File: rtl/victim_buffer_chk.sv
module victim_buffer_chk #(
   parameter int unsigned ENTRIES = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               evict_valid,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               wb_valid,
   input logic [ENTRIES-1:0] match_vec,
   input logic [ENTRIES-1:0] valid_vec
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_QUIET_IN_RESET: assert (!rsp_valid && !wb_valid); // R1
      end
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2

   AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec)); // R3

   AST_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (rsp_valid && !rsp_hit)); // R7

   AST_WB_NEEDS_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(evict_valid)); // R7

   AST_IDLE_KEEPS_ENTRIES: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(valid_vec)); // R8

endmodule

bind victim_buffer victim_buffer_chk #(.ENTRIES(ENTRIES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .evict_valid (evict_valid),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .wb_valid    (wb_valid),
   .match_vec   (match_vec),
   .valid_vec   (valid_vec)
);

// File: tb/victim_buffer_tb_top.sv
`timescale 1ns/1ps
module victim_buffer_tb_top;

   localparam int AW = 26;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          evict_valid = 1'b0;
   logic [AW-1:0] evict_addr = '0;
   logic [DW-1:0] evict_data = '0;
   logic          evict_dirty = 1'b0;
   logic          rsp_valid, rsp_hit, rsp_dirty, wb_valid;
   logic [DW-1:0] rsp_data, wb_data;
   logic [AW-1:0] wb_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   victim_buffer dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .evict_data(evict_data), .evict_dirty(evict_dirty),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .rsp_dirty(rsp_dirty), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .wb_data(wb_data)
   );

   function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
      return {6'h0, a, 6'h0, ~a};
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // one lookup; outputs sampled 1 ns after the capturing edge
   task automatic access(input bit rq, input logic [AW-1:0] ra, input bit ev,
                         input logic [AW-1:0] ea, input bit ed);
      @(negedge clk);
      req_valid   = rq;
      req_addr    = ra;
      evict_valid = ev;
      evict_addr  = ea;
      evict_data  = line_of(ea);
      evict_dirty = ed;
      @(posedge clk);
      #1;
      req_valid   = 1'b0;
      evict_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [3:0]    rtag;
      logic          rq;
      logic [AW-1:0] ra;
      logic          ev;
      logic [AW-1:0] ea;
      logic          ed;
      logic          xh;
      logic          xd;
      logic          xw;
      logic [AW-1:0] xwa;
   } vec_t;

   localparam int NV = 19;
   // After the fill loop slot i holds 0x100+i, dirty when i is odd; ring at slot 0.
   localparam vec_t VECS [NV] = '{
      '{4'd4, 1'b1, 26'h105, 1'b1, 26'h300, 1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R3 R4 swap
      '{4'd4, 1'b1, 26'h300, 1'b0, 26'h0,   1'b0, 1'b1, 1'b0, 1'b0, 26'h0},   // R4 swapped-in line
      '{4'd5, 1'b1, 26'h300, 1'b0, 26'h0,   1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R5 dropped
      '{4'd4, 1'b1, 26'h105, 1'b0, 26'h0,   1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R4 old line gone
      '{4'd7, 1'b1, 26'h600, 1'b1, 26'h400, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 clean displaced
      '{4'd7, 1'b1, 26'h601, 1'b1, 26'h401, 1'b1, 1'b0, 1'b0, 1'b1, 26'h101}, // R7 dirty displaced
      '{4'd6, 1'b1, 26'h100, 1'b0, 26'h0,   1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R6 replaced
      '{4'd6, 1'b1, 26'h401, 1'b0, 26'h0,   1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R6 inserted
      '{4'd8, 1'b0, 26'h0,   1'b1, 26'h500, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R8 idle evict
      '{4'd8, 1'b1, 26'h500, 1'b0, 26'h0,   1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R8 not stored
      '{4'd8, 1'b1, 26'h602, 1'b1, 26'h402, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R8 ring at slot 2
      '{4'd9, 1'b1, 26'h103, 1'b0, 26'h0,   1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R9 misses left it
      '{4'd7, 1'b1, 26'h604, 1'b1, 26'h404, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 empty slot 3
      '{4'd7, 1'b1, 26'h605, 1'b1, 26'h405, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 clean slot 4
      '{4'd7, 1'b1, 26'h606, 1'b1, 26'h406, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 empty slot 5
      '{4'd7, 1'b1, 26'h607, 1'b1, 26'h407, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 clean slot 6
      '{4'd7, 1'b1, 26'h608, 1'b1, 26'h408, 1'b0, 1'b0, 1'b0, 1'b1, 26'h107}, // R7 dirty slot 7
      '{4'd6, 1'b1, 26'h404, 1'b0, 26'h0,   1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R6 dirty kept
      '{4'd6, 1'b1, 26'h108, 1'b0, 26'h0,   1'b0, 1'b1, 1'b0, 1'b0, 26'h0}    // R6 untouched slot 8
   };

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] l1_tag [4];
      logic          l1_v   [4];

      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      chk(!rsp_valid && !wb_valid, "R1 outputs in reset", {rsp_valid, wb_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(!rsp_valid && !wb_valid, "R1 outputs after reset", {rsp_valid, wb_valid}, 0);

      // R1 R2: empty lookup misses, result one cycle later
      access(1'b1, 26'h10, 1'b0, 26'h0, 1'b0);
      chk(rsp_valid, "R2 rsp_valid after req", rsp_valid, 1);
      chk(!rsp_hit, "R1 empty buffer misses", rsp_hit, 0);
      @(posedge clk);
      #1;
      chk(!rsp_valid, "R2 rsp_valid drops", rsp_valid, 0);

      // R6 fill all slots
      for (int i = 0; i < 16; i++) begin
         access(1'b1, AW'(32'h200 + i), 1'b1, AW'(32'h100 + i), i[0]);
         chk(rsp_valid && !rsp_hit && !wb_valid, "R6 fill miss, no write-back",
             {rsp_valid, rsp_hit, wb_valid}, 3'b100);
      end

      // table walk
      for (int k = 0; k < NV; k++) begin
         access(VECS[k].rq, VECS[k].ra, VECS[k].ev, VECS[k].ea, VECS[k].ed);
         chk(rsp_valid == VECS[k].rq, $sformatf("R2 vec%0d valid", k), rsp_valid, VECS[k].rq);
         chk(rsp_hit == VECS[k].xh, $sformatf("R%0d vec%0d hit", VECS[k].rtag, k),
             rsp_hit, VECS[k].xh);
         if (VECS[k].xh) begin
            chk(rsp_data == line_of(VECS[k].ra), $sformatf("R3 vec%0d data", k),
                rsp_data, line_of(VECS[k].ra));
            chk(rsp_dirty == VECS[k].xd, $sformatf("R3 vec%0d dirty", k), rsp_dirty, VECS[k].xd);
         end
         chk(wb_valid == VECS[k].xw, $sformatf("R7 vec%0d wb_valid", k), wb_valid, VECS[k].xw);
         if (VECS[k].xw) begin
            chk(wb_addr == VECS[k].xwa, $sformatf("R7 vec%0d wb_addr", k), wb_addr, VECS[k].xwa);
            chk(wb_data == line_of(VECS[k].xwa), $sformatf("R7 vec%0d wb_data", k),
                wb_data, line_of(VECS[k].xwa));
         end
      end

      // R1 reset mid-run empties the buffer
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk(!rsp_valid && !wb_valid, "R1 quiet in second reset", {rsp_valid, wb_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b1, 26'h404, 1'b0, 26'h0, 1'b0);
      chk(!rsp_hit, "R1 entries cleared", rsp_hit, 0);

      // R10 alternating same-index stream with a 4-set direct-mapped model
      for (int s = 0; s < 4; s++) l1_v[s] = 1'b0;
      for (int n = 0; n < 12; n++) begin
         logic [AW-1:0] a;
         logic [1:0]    ix;
         bit            l1_hit;
         a  = n[0] ? 26'h2004 : 26'h1000;
         ix = a[1:0];
         l1_hit = l1_v[ix] && (l1_tag[ix] == a);
         if (!l1_hit) begin
            access(1'b1, a, l1_v[ix], l1_tag[ix], 1'b0);
            if (rsp_hit)
               chk(rsp_data == line_of(a), "R10 buffer data", rsp_data, line_of(a));
            if (n >= 2)
               chk(rsp_hit, $sformatf("R10 access %0d served", n), rsp_hit, 1);
            l1_v[ix]   = 1'b1;
            l1_tag[ix] = a;
         end else if (n >= 2) begin
            chk(1'b1, "R10 primary hit", 1, 1);
         end
      end

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule